// File: doc/BRIEF.md
# Dual-Master Clock Configuration Ownership Semaphore

Two bus masters share one bank of clock configuration registers. This block decides which of them may write that bank at any moment. Each master owns a 2-bit request register that it writes to claim or give up ownership. The block holds a 2-bit semaphore that both masters can read back.

It then forwards only the owner's write strobe, address and data to the shared bank. The other master's configuration writes never arrive there.

Ownership is asymmetric. Master A owns the bank by default while the semaphore is idle. Master A can claim the bank explicitly, which locks out master B. Master B has to claim the bank before its writes take effect. The semaphore never moves directly from one claimed state to the other. The current owner must release first.

Every request write that the block ignores produces a one-cycle refused pulse for the master that wrote it.

Top module: `clk_owner_sem`

## Requirements
- R1: After reset is released, `sem_state` reads 00 (idle), `owner_is_b` is 0, and both refused outputs are 0.
- R2: In state 00, a master A request write of 10 moves `sem_state` to 10 on the next clock edge (A holds an explicit claim).
- R3: In state 10, a master A request write of 00 moves `sem_state` back to 00 on the next clock edge.
- R4: In state 00, a master B request write of 01 (with no accepted A claim in the same cycle) moves `sem_state` to 01 on the next clock edge. `owner_is_b` is 1 exactly while the state is 01.
- R5: In state 01, a master B request write of 00 moves `sem_state` back to 00 on the next clock edge.
- R6: A claim by master B in state 10 is refused, and so is a claim by master A in state 01. `sem_state` never goes directly between 10 and 01.
- R7: While the state is 01, `cfg_we`, `cfg_addr` and `cfg_wdata` carry master B's strobe, address and data. In states 00 and 10 they carry master A's. The non-owner's writes never reach the bank.
- R8: Any request write that does not cause a transition under R2 to R5 leaves `sem_state` unchanged. This covers code 11, the other master's claim code, and a release by a master that holds no claim. `sem_state` never reads 11.
- R9: If both masters write their claim codes in the same cycle while the state is 00, the state becomes 10. Master B's claim is dropped and B gets a refused pulse.
- R10: `a_refused` or `b_refused` is 1 for exactly the one cycle after an ignored request write by that master. It is 0 after an accepted write and after cycles with no request write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_req_we | input | 1 | Master A request register write strobe |
| a_req_data | input | 2 | Master A request code (10 claim, 00 release) |
| b_req_we | input | 1 | Master B request register write strobe |
| b_req_data | input | 2 | Master B request code (01 claim, 00 release) |
| a_cfg_we | input | 1 | Master A configuration write strobe |
| a_cfg_addr | input | ADDR_W | Master A configuration address |
| a_cfg_wdata | input | DATA_W | Master A configuration write data |
| b_cfg_we | input | 1 | Master B configuration write strobe |
| b_cfg_addr | input | ADDR_W | Master B configuration address |
| b_cfg_wdata | input | DATA_W | Master B configuration write data |
| cfg_we | output | 1 | Write strobe forwarded to the shared bank |
| cfg_addr | output | ADDR_W | Address forwarded to the shared bank |
| cfg_wdata | output | DATA_W | Data forwarded to the shared bank |
| sem_state | output | 2 | Semaphore value, readable by both masters |
| owner_is_b | output | 1 | 1 while master B owns the bank |
| a_refused | output | 1 | One-cycle pulse after an ignored A request write |
| b_refused | output | 1 | One-cycle pulse after an ignored B request write |

## Verification
The bench builds the block with ADDR_W = 4 and DATA_W = 8. The configuration path has no effect on arbitration, so these narrow widths lose no behaviour.

The semaphore has three reachable states and each master has four request codes with a strobe. That makes the full space of both masters' request writes only 64 combinations per state. The bench sweeps every combination from every state, including simultaneous claims and foreign codes.

It also sweeps both configuration strobes in every state, using address and data values derived from the sweep index. This shows that only the owner's bus reaches the shared bank.

// File: rtl/clk_owner_sem.sv
module clk_owner_sem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_req_we,
  input  logic [1:0]        a_req_data,
  input  logic              b_req_we,
  input  logic [1:0]        b_req_data,
  input  logic              a_cfg_we,
  input  logic [ADDR_W-1:0] a_cfg_addr,
  input  logic [DATA_W-1:0] a_cfg_wdata,
  input  logic              b_cfg_we,
  input  logic [ADDR_W-1:0] b_cfg_addr,
  input  logic [DATA_W-1:0] b_cfg_wdata,
  output logic              cfg_we,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [DATA_W-1:0] cfg_wdata,
  output logic [1:0]        sem_state,
  output logic              owner_is_b,
  output logic              a_refused,
  output logic              b_refused
);

  localparam logic [1:0] IDLE   = 2'b00;
  localparam logic [1:0] A_HELD = 2'b10;
  localparam logic [1:0] B_HELD = 2'b01;

  logic [1:0] sem_q, sem_d;
  logic       a_take, a_drop, b_take, b_drop;
  logic       a_ok, b_ok;

  assign a_take = a_req_we && sem_q == IDLE   && a_req_data == A_HELD;
  assign a_drop = a_req_we && sem_q == A_HELD && a_req_data == IDLE;
  assign b_take = b_req_we && sem_q == IDLE   && b_req_data == B_HELD && !a_take;
  assign b_drop = b_req_we && sem_q == B_HELD && b_req_data == IDLE;
  assign a_ok   = a_take || a_drop;
  assign b_ok   = b_take || b_drop;

  always_comb begin
    sem_d = sem_q;
    if (a_take)      sem_d = A_HELD;
    else if (b_take) sem_d = B_HELD;
    else if (a_drop || b_drop) sem_d = IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sem_q     <= IDLE;
      a_refused <= 1'b0;
      b_refused <= 1'b0;
    end else begin
      sem_q     <= sem_d;
      a_refused <= a_req_we && !a_ok;
      b_refused <= b_req_we && !b_ok;
    end
  end

  assign sem_state  = sem_q;
  assign owner_is_b = sem_q == B_HELD;
  assign cfg_we     = owner_is_b ? b_cfg_we    : a_cfg_we;
  assign cfg_addr   = owner_is_b ? b_cfg_addr  : a_cfg_addr;
  assign cfg_wdata  = owner_is_b ? b_cfg_wdata : a_cfg_wdata;

  assert_never_11_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sem_state != 2'b11);

  assert_no_a_to_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sem_state == A_HELD |=> sem_state != B_HELD);

  assert_no_b_to_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sem_state == B_HELD |=> sem_state != A_HELD);

  assert_b_claim_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_state == A_HELD && b_req_we && b_req_data == B_HELD) |=> b_refused);

  assert_a_claim_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_state == B_HELD && a_req_we && a_req_data == A_HELD) |=> a_refused);

  assert_tie_a_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_state == IDLE && a_req_we && a_req_data == A_HELD &&
     b_req_we && b_req_data == B_HELD) |=> (sem_state == A_HELD && b_refused));

  assert_a_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_state == B_HELD && a_cfg_we && !b_cfg_we) |-> !cfg_we);

  assert_b_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_state != B_HELD && b_cfg_we && !a_cfg_we) |-> !cfg_we);

  assert_quiet_no_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_req_we && !b_req_we) |=> (!a_refused && !b_refused && $stable(sem_state)));

endmodule

// File: tb/clk_owner_sem_tb.sv
module clk_owner_sem_tb_top;
  localparam int AW = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_req_we = 0, b_req_we = 0, a_cfg_we = 0, b_cfg_we = 0;
  logic [1:0] a_req_data = 0, b_req_data = 0;
  logic [AW-1:0] a_cfg_addr = 0, b_cfg_addr = 0;
  logic [DW-1:0] a_cfg_wdata = 0, b_cfg_wdata = 0;
  logic cfg_we, owner_is_b, a_refused, b_refused;
  logic [AW-1:0] cfg_addr;
  logic [DW-1:0] cfg_wdata;
  logic [1:0] sem_state;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  clk_owner_sem #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    a_req_we = 0; b_req_we = 0; a_cfg_we = 0; b_cfg_we = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic req(input logic awe, input logic [1:0] ad,
                     input logic bwe, input logic [1:0] bd);
    a_req_we = awe; a_req_data = ad; b_req_we = bwe; b_req_data = bd;
    @(negedge clk);
    a_req_we = 0; b_req_we = 0;
  endtask

  task automatic go_state(input logic [1:0] s);
    do_reset();
    if (s == 2'b10) req(1, 2'b10, 0, 0);
    if (s == 2'b01) req(0, 0, 1, 2'b01);
  endtask

  function automatic string tag_of(input logic [1:0] s, input logic aw, input logic [1:0] ad,
                                   input logic bw, input logic [1:0] bd);
    if (s == 0 && aw && ad == 2 && bw && bd == 1) return "R9";
    if (s == 0 && aw && ad == 2) return "R2";
    if (s == 2 && aw && ad == 0) return "R3";
    if (s == 0 && bw && bd == 1) return "R4";
    if (s == 1 && bw && bd == 0) return "R5";
    if ((s == 2 && bw && bd == 1) || (s == 1 && aw && ad == 2)) return "R6";
    return "R8";
  endfunction

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    join_none

    do_reset();
    check("R1 sem", sem_state, 0);
    check("R1 owner", owner_is_b, 0);
    check("R1 refused", {a_refused, b_refused}, 0);

    for (int si = 0; si < 3; si++) begin
      logic [1:0] s;
      s = (si == 0) ? 2'b00 : (si == 1) ? 2'b10 : 2'b01;
      for (int v = 0; v < 64; v++) begin
        logic aw, bw, a_ok, b_ok;
        logic [1:0] ad, bd, nx;
        string t;
        aw = v[5]; ad = v[4:3]; bw = v[2]; bd = v[1:0];
        a_ok = aw && ((s == 0 && ad == 2) || (s == 2 && ad == 0));
        b_ok = bw && ((s == 0 && bd == 1 && !a_ok) || (s == 1 && bd == 0));
        nx = a_ok ? ((s == 0) ? 2'b10 : 2'b00) : b_ok ? ((s == 0) ? 2'b01 : 2'b00) : s;
        t = tag_of(s, aw, ad, bw, bd);
        go_state(s);
        check("R1 setup", sem_state, s);
        req(aw, ad, bw, bd);
        check({t, " sem"}, sem_state, nx);
        check("R4 owner", owner_is_b, nx == 2'b01);
        check({t, " R10 a_refused"}, a_refused, aw && !a_ok);
        check({t, " R10 b_refused"}, b_refused, bw && !b_ok);
        @(negedge clk);
        check("R10 pulse one cycle", {a_refused, b_refused}, 0);
      end
    end

    for (int si = 0; si < 3; si++) begin
      logic [1:0] s;
      s = (si == 0) ? 2'b00 : (si == 1) ? 2'b10 : 2'b01;
      go_state(s);
      for (int v = 0; v < 4; v++) begin
        logic bsel;
        bsel = (s == 2'b01);
        a_cfg_we = v[0]; b_cfg_we = v[1];
        a_cfg_addr = 4'(3 * v + si); b_cfg_addr = 4'(15 - v - si);
        a_cfg_wdata = 8'(17 * v + 5 * si); b_cfg_wdata = 8'(200 - 9 * v - si);
        #1;
        check("R7 we", cfg_we, bsel ? v[1] : v[0]);
        check("R7 addr", cfg_addr, bsel ? 15 - v - si : (3 * v + si) % 16);
        check("R7 data", cfg_wdata, bsel ? (200 - 9 * v - si) % 256 : (17 * v + 5 * si) % 256);
        @(negedge clk);
      end
      a_cfg_we = 0; b_cfg_we = 0;
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule